// File: doc/BRIEF.md
# Keypad Matrix Scan Controller

This block sits between a host and a small key matrix of three key groups by four sense lines. It drives one enable line per group and reads four sense lines back; a pressed key pulls its sense line to 1 while its group is enabled. A host can drive the enable lines by hand through an 8-bit scan register and read the enables and the sensed lines back. This also exposes the raw sense vector when no group is enabled, so lines that are forced high can be seen.

With auto mode on, a scanner enables the groups one at a time in a fixed order. Each group is held for a settle time, the sense lines are sampled at the end of it, and the three samples are packed into a 12-bit key mask. The mask is committed in one step with a one-cycle valid strobe, and scanning repeats for as long as auto mode stays on. A decoder turns the committed mask into named button bits for one of two handset layouts. It also raises a flag when the positions that the layout fixes hold their expected level.

Top module: `keypad_scan_top`

## Requirements
- R1: `hostRdData` reads as {0, enables now driven on `grpEn[2:0]` in bits 6:4, `senseIn` as registered one cycle earlier in bits 3:0}. With no group enabled, bits 3:0 report the raw sense lines, and with several groups enabled they report the lines as they arrive.
- R2: A scan drives exactly one enable at a time: `grpEn[0]` (scan register bit 4), then `grpEn[1]` (bit 5), then `grpEn[2]` (bit 6). Each is held for exactly `SETTLE_CYCLES` cycles (default 8), with no gap between groups.
- R3: `keyMask[11:8]` holds the `grpEn[0]` sample, `keyMask[7:4]` the `grpEn[1]` sample and `keyMask[3:0]` the `grpEn[2]` sample. `keyMask[15:12]` is always 0.
- R4: Each group's sample is the value of `senseIn` in the last cycle of that group's settle window. Key changes earlier in the window do not appear in the sample.
- R5: `keyMask` changes only in the cycle after the third group is sampled, in which `maskValid` is high for exactly one cycle. In every other cycle `keyMask` holds its value.
- R6: A host write (`hostWrEn`, enables taken from `hostWrData[6:4]`) is ignored while a scan is active. When idle, the write is accepted and `grpEn` follows the written value from the next cycle.
- R7: Auto mode (`ctlWrEn` with `ctlAuto`) starts a scan on the second cycle after the write and repeats scans back to back. After auto mode is cleared, the scan in progress completes with its commit. After that `grpEn` returns to the host-written enables and no further `maskValid` occurs.
- R8: Layout A (`ctlLayout`=0): `btnOut[3:0]`=Y1..Y4 from mask bits 8..11, `btnOut[7:4]`=X1..X4 from mask bits 4..7, `btnOut[8]`=Start (mask bit 1), `btnOut[9]`=A (bit 2), `btnOut[10]`=B (bit 3).
- R9: Layout B (`ctlLayout`=1): `btnOut` bits 0..8 are Left (mask bit 0), Down (2), Up (3), View (4), Esc (6), Right (7), Clear (8), Circle (10) and Pass (11). `btnOut[10:9]`=0.
- R10: `fixedOk` is 1 when, in layout A, mask bit 0 is 0 or, in layout B, mask bits 1, 5 and 9 are all 1. Otherwise it is 0.
- R11: After reset, `grpEn`=0, `keyMask`=0, `maskValid`=0, auto mode is off (no scan starts on its own) and layout A is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe for the scan register |
| hostWrData | input | 8 | Scan register write value; bits 6:4 are the enables |
| hostRdData | output | 8 | Scan register readback |
| ctlWrEn | input | 1 | Write strobe for mode controls |
| ctlAuto | input | 1 | Auto-scan enable value |
| ctlLayout | input | 1 | Handset layout select (0 = A, 1 = B) |
| grpEn | output | 3 | Group enable lines to the matrix |
| senseIn | input | 4 | Sense lines from the matrix |
| keyMask | output | 16 | Committed packed key mask |
| maskValid | output | 1 | One-cycle strobe on mask commit |
| btnOut | output | 11 | Decoded buttons for the selected layout |
| fixedOk | output | 1 | Layout's fixed positions read as expected |

## Verification
The hardest case to reach is a key that changes inside a group's settle window. The new value must be sampled only in the window's last cycle. The bench lines this up by waiting for a commit strobe, which marks the exact start of the next first-group window. It presses keys there and changes them a few cycles later, well before that window closes. A second hard case is clearing auto mode in the middle of a scan. That is reached from the same commit point, so the remaining scan, its final commit and the hand-back to host-driven enables all follow at known cycles.

// File: rtl/keypad_scan_pkg.sv
package keypad_scan_pkg;
  localparam int GROUPS  = 3;
  localparam int SENSE_W = 4;
  localparam int GRP_W   = $clog2(GROUPS);
  localparam int MASK_W  = 16;
  localparam int PACK_W  = GROUPS * SENSE_W;
  localparam int BTN_W   = 11;

  typedef enum logic {
    LAYOUT_A = 1'b0,
    LAYOUT_B = 1'b1
  } layout_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scanState_e;

  // Strobes from the scan control to the datapath
  typedef struct packed {
    logic              scanActive;
    logic [GROUPS-1:0] scanEn;
    logic              capture;
    logic [GRP_W-1:0]  slot;
    logic              commit;
  } scanStrb_t;
endpackage

// File: rtl/keypad_scan_ctrl.sv
module keypad_scan_ctrl
  import keypad_scan_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctlWrEn,
  input  logic      ctlAuto,
  output scanStrb_t strb
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUPS - 1);

  scanState_e       state;
  logic             autoOn;
  logic [CNT_W-1:0] settleCnt;
  logic [GRP_W-1:0] grpIdx;
  logic             windowEnd;

  assign windowEnd = (state == ST_SCAN) && (settleCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      autoOn    <= 1'b0;
      settleCnt <= '0;
      grpIdx    <= '0;
    end else begin
      if (ctlWrEn) autoOn <= ctlAuto;
      case (state)
        ST_IDLE: begin
          if (autoOn) begin
            state     <= ST_SCAN;
            grpIdx    <= '0;
            settleCnt <= '0;
          end
        end
        ST_SCAN: begin
          if (windowEnd) begin
            settleCnt <= '0;
            if (grpIdx == GRP_LAST) begin
              grpIdx <= '0;
              if (!autoOn) state <= ST_IDLE;
            end else begin
              grpIdx <= grpIdx + 1'b1;
            end
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb            = '0;
    strb.scanActive = (state == ST_SCAN);
    strb.capture    = windowEnd;
    strb.slot       = grpIdx;
    strb.commit     = windowEnd && (grpIdx == GRP_LAST);
    for (int g = 0; g < GROUPS; g++) begin
      strb.scanEn[g] = strb.scanActive && (grpIdx == GRP_W'(g));
    end
  end
endmodule

// File: rtl/keypad_scan_dp.sv
module keypad_scan_dp
  import keypad_scan_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  scanStrb_t          strb,
  input  logic               hostWrEn,
  input  logic [GROUPS-1:0]  hostWrEn3,
  input  logic               ctlWrEn,
  input  logic               ctlLayout,
  input  logic [SENSE_W-1:0] senseIn,
  output logic [GROUPS-1:0]  grpEn,
  output logic [7:0]         hostRdData,
  output logic [MASK_W-1:0]  keyMask,
  output logic               maskValid,
  output layout_e            layoutSel
);
  logic [GROUPS-1:0]  hostEn;
  logic [SENSE_W-1:0] senseReg;
  logic [PACK_W-1:0]  packNext;
  logic [GROUPS-2:0][SENSE_W-1:0] shadow;

  assign grpEn      = strb.scanActive ? strb.scanEn : hostEn;
  assign hostRdData = {1'b0, grpEn, senseReg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostEn    <= '0;
      senseReg  <= '0;
      keyMask   <= '0;
      maskValid <= 1'b0;
      layoutSel <= LAYOUT_A;
    end else begin
      senseReg  <= senseIn;
      maskValid <= strb.commit;
      if (hostWrEn && !strb.scanActive) hostEn <= hostWrEn3;
      if (ctlWrEn) layoutSel <= layout_e'(ctlLayout);
      if (strb.commit) keyMask <= {{(MASK_W-PACK_W){1'b0}}, packNext};
    end
  end

  // First group lands in the top nibble; the last group is taken live.
  for (genvar g = 0; g < GROUPS; g++) begin : gSlot
    localparam int HI = PACK_W - 1 - g * SENSE_W;
    if (g == GROUPS - 1) begin : gLive
      assign packNext[HI -: SENSE_W] = senseIn;
    end else begin : gHeld
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shadow[g] <= '0;
        else if (strb.capture && strb.slot == GRP_W'(g)) shadow[g] <= senseIn;
      end
      assign packNext[HI -: SENSE_W] = shadow[g];
    end
  end
endmodule

// File: rtl/keypad_btn_decode.sv
module keypad_btn_decode
  import keypad_scan_pkg::*;
(
  input  logic [PACK_W-1:0] mask,
  input  layout_e           layoutSel,
  output logic [BTN_W-1:0]  btnOut,
  output logic              fixedOk
);
  logic [BTN_W-1:0] btnA;
  logic [BTN_W-1:0] btnB;

  // Layout A: direction pads on the two upper groups, action keys below
  assign btnA = {mask[3], mask[2], mask[1], mask[7:4], mask[11:8]};

  // Layout B: column 1 is tied high on this handset, so skipped
  assign btnB = {2'b00, mask[11], mask[10], mask[8], mask[7], mask[6],
                 mask[4], mask[3], mask[2], mask[0]};

  always_comb begin
    if (layoutSel == LAYOUT_B) begin
      btnOut  = btnB;
      fixedOk = mask[9] & mask[5] & mask[1];
    end else begin
      btnOut  = btnA;
      fixedOk = ~mask[0];
    end
  end
endmodule

// File: rtl/keypad_scan_top.sv
module keypad_scan_top
  import keypad_scan_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic [7:0]  hostWrData,
  output logic [7:0]  hostRdData,
  input  logic        ctlWrEn,
  input  logic        ctlAuto,
  input  logic        ctlLayout,
  output logic [2:0]  grpEn,
  input  logic [3:0]  senseIn,
  output logic [15:0] keyMask,
  output logic        maskValid,
  output logic [10:0] btnOut,
  output logic        fixedOk
);
  scanStrb_t strb;
  layout_e   layoutSel;
  logic      unusedWrBits;

  assign unusedWrBits = ^{hostWrData[7], hostWrData[3:0]};

  keypad_scan_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctlWrEn (ctlWrEn),
    .ctlAuto (ctlAuto),
    .strb    (strb)
  );

  keypad_scan_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .hostWrEn   (hostWrEn),
    .hostWrEn3  (hostWrData[6:4]),
    .ctlWrEn    (ctlWrEn),
    .ctlLayout  (ctlLayout),
    .senseIn    (senseIn),
    .grpEn      (grpEn),
    .hostRdData (hostRdData),
    .keyMask    (keyMask),
    .maskValid  (maskValid),
    .layoutSel  (layoutSel)
  );

  keypad_btn_decode u_dec (
    .mask      (keyMask[PACK_W-1:0]),
    .layoutSel (layoutSel),
    .btnOut    (btnOut),
    .fixedOk   (fixedOk)
  );
endmodule

// File: rtl/keypad_scan_chk.sv
module keypad_scan_chk
  import keypad_scan_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input scanStrb_t   strb,
  input logic [2:0]  grpEn,
  input logic [15:0] keyMask,
  input logic        maskValid
);
  p_onehot_scan_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.scanActive |-> $onehot(grpEn));

  p_order_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && grpEn[0]) |=> grpEn[1]);

  p_order_second_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && grpEn[1]) |=> grpEn[2]);

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    maskValid |=> !maskValid);

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !maskValid |-> $stable(keyMask));

  p_valid_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    maskValid |-> $past(grpEn[2]));
endmodule

bind keypad_scan_top keypad_scan_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .strb      (strb),
  .grpEn     (grpEn),
  .keyMask   (keyMask),
  .maskValid (maskValid)
);

// File: tb/keypad_scan_top_test.sv
`timescale 1ns/1ps
module keypad_scan_top_test;
  localparam int S = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostWrData = '0;
  logic        ctlWrEn = 1'b0;
  logic        ctlAuto = 1'b0;
  logic        ctlLayout = 1'b0;
  logic [2:0]  grpEn;
  logic [3:0]  senseIn;
  logic [7:0]  hostRdData;
  logic [15:0] keyMask;
  logic        maskValid;
  logic [10:0] btnOut;
  logic        fixedOk;

  // Matrix environment: pressed keys per group plus lines forced high
  logic [3:0] keys [3];
  logic [3:0] forced = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keypad_scan_top #(.SETTLE_CYCLES(S)) uut (.*);

  function automatic logic [3:0] matrix(logic [2:0] en);
    logic [3:0] v = forced;
    for (int g = 0; g < 3; g++) if (en[g]) v |= keys[g];
    return v;
  endfunction

  always_comb senseIn = matrix(grpEn);

  // Behavioural reference model
  int         mState, mCnt, mGrp;
  bit         mAuto, mLayout, mValid;
  logic [2:0] mHostEn;
  logic [3:0] mSense;
  logic [3:0] mHeld [3];
  logic [15:0] mMask;

  function automatic logic [2:0] mEn();
    return (mState == 1) ? 3'(1 << mGrp) : mHostEn;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mGrp = 0; mAuto = 0; mLayout = 0; mValid = 0;
      mHostEn = 0; mSense = 0; mMask = 0;
    end else begin
      logic [3:0] s;
      s = matrix(mEn());
      if (hostWrEn && mState == 0) mHostEn = hostWrData[6:4];
      mSense = s;
      mValid = 0;
      if (mState == 1) begin
        if (mCnt == S - 1) begin
          mHeld[mGrp] = s;
          mCnt = 0;
          if (mGrp == 2) begin
            mMask = {4'h0, mHeld[0], mHeld[1], mHeld[2]};
            mValid = 1;
            mGrp = 0;
            if (!mAuto) mState = 0;
          end else mGrp++;
        end else mCnt++;
      end else if (mAuto) begin
        mState = 1; mGrp = 0; mCnt = 0;
      end
      if (ctlWrEn) begin mAuto = ctlAuto; mLayout = ctlLayout; end
    end
  end

  function automatic logic [10:0] expBtn(logic [15:0] m, bit lay);
    if (!lay) return {m[3], m[2], m[1], m[7:4], m[11:8]};
    return {2'b00, m[11], m[10], m[8], m[7], m[6], m[4], m[3], m[2], m[0]};
  endfunction

  function automatic logic expFixed(logic [15:0] m, bit lay);
    return lay ? (m[9] & m[5] & m[1]) : ~m[0];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rstN) begin
      chk("R2 R6 R7 grpEn", 32'(grpEn), 32'(mEn()));
      chk("R1 hostRdData", 32'(hostRdData), 32'({1'b0, mEn(), mSense}));
      chk("R3 R4 keyMask", 32'(keyMask), 32'(mMask));
      chk("R5 maskValid", 32'(maskValid), 32'(mValid));
      chk(mLayout ? "R9 btnOut" : "R8 btnOut", 32'(btnOut), 32'(expBtn(mMask, mLayout)));
      chk("R10 fixedOk", 32'(fixedOk), 32'(expFixed(mMask, mLayout)));
    end
  endtask

  task automatic hostWrite(logic [2:0] en);
    hostWrEn = 1; hostWrData = {1'b0, en, 4'h0};
    step();
    hostWrEn = 0; hostWrData = '0;
  endtask

  task automatic ctlWrite(bit au, bit lay);
    ctlWrEn = 1; ctlAuto = au; ctlLayout = lay;
    step();
    ctlWrEn = 0;
  endtask

  task automatic waitValid(string tag);
    bit seen = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      step();
      if (maskValid) seen = 1;
    end
    chk({tag, " commit seen"}, 32'(seen), 32'd1);
  endtask

  initial begin
    keys[0] = 0; keys[1] = 0; keys[2] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state and no self-start
    chk("R11 grpEn", 32'(grpEn), 0);
    chk("R11 keyMask", 32'(keyMask), 0);
    chk("R11 maskValid", 32'(maskValid), 0);
    chk("R11 fixedOk layout A", 32'(fixedOk), 1);
    repeat (6) step();
    chk("R11 still idle", 32'(grpEn), 0);

    // R1 raw vector with nothing enabled, then single and multiple groups
    forced = 4'b0101; step(); step();
    chk("R1 raw sense", 32'(hostRdData), 32'h05);
    forced = 0; keys[0] = 4'b0011; keys[1] = 4'b1000;
    hostWrite(3'b001); step();
    chk("R1 group0 readback", 32'(hostRdData), 32'h13);
    hostWrite(3'b011); step();
    chk("R1 OR of groups", 32'(hostRdData), 32'h3B);

    // R2 R3 R8 layout A auto scan; R6 host write during scan ignored
    keys[0] = 4'b1001; keys[1] = 4'b0110; keys[2] = 4'b1010;
    ctlWrite(1, 0);
    repeat (4) step();
    hostWrite(3'b111);
    chk("R6 write ignored in scan", 32'(grpEn), 32'h1);
    waitValid("R5");
    chk("R3 packed mask", 32'(keyMask), 32'h096A);
    chk("R8 layout A buttons", 32'(btnOut), 32'h569);
    chk("R10 layout A ok", 32'(fixedOk), 1);
    step();
    chk("R5 single pulse", 32'(maskValid), 0);

    // R4 only the last settle cycle counts
    keys[0] = 4'b1111;
    repeat (3) step();
    keys[0] = 4'b0011;
    waitValid("R4");
    chk("R4 late sample", 32'(keyMask[11:8]), 32'h3);

    // R9 R10 layout B with column 1 held high
    forced = 4'b0010; keys[0] = 4'b1001; keys[1] = 4'b0100; keys[2] = 4'b1000;
    ctlWrite(1, 1);
    waitValid("R9");
    waitValid("R9");
    chk("R9 mask", 32'(keyMask), 32'h0B6A);
    chk("R9 layout B buttons", 32'(btnOut), 32'h154);
    chk("R10 layout B ok", 32'(fixedOk), 1);
    forced = 0;
    waitValid("R10");
    waitValid("R10");
    chk("R10 layout B missing column", 32'(fixedOk), 0);

    // R7 stop mid scan: scan completes, then host enables return
    repeat (5) step();
    ctlWrite(0, 1);
    waitValid("R7");
    chk("R7 host enables back", 32'(grpEn), 32'h3);
    begin
      bit extra = 0;
      for (int i = 0; i < 40; i++) begin
        step();
        if (maskValid) extra = 1;
      end
      chk("R7 no further commit", 32'(extra), 0);
    end
    hostWrite(3'b100); step();
    chk("R6 idle write accepted", 32'(grpEn), 32'h4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R5 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule